// File: doc/BRIEF.md
# Inbound Interrupt Status Aggregator

This block gathers interrupt sources for a messaging unit and presents them to a processor as a 32-bit status word, a companion mask word and two interrupt lines. Five sources are sticky: strobes for writes to either inbound message register, a post-queue write, an index-register write caused by a bus transaction, and an outbound free-queue full condition. The free-queue condition is the head pointer equalling the tail pointer while the full flag is high. Two further status bits are not stored here. They mirror live doorbell summary levels that are owned by another register.

Software reads status and mask through a small register port and clears sticky bits by writing ones. A mask bit stops its status bit from raising an interrupt, but the event is still recorded. Status bits 3 and 5 feed the normal interrupt line. Every other status bit feeds the fast interrupt line. Both lines are registered.

Top module: `inb_irq_status`

## Requirements
- R1: During and after synchronous reset, all sticky status bits, all mask bits and both interrupt outputs are 0.
- R2: Word index 0 reads status in bits 6:0, and word index 1 reads mask in bits 6:0. Bits 31:7 of both read 0, and writes to them have no effect. Any other word index reads 0 and ignores writes.
- R3: A one-cycle strobe on msg0_wr_evt, msg1_wr_evt, post_q_wr_evt or index_wr_evt sets status bit 0, 1, 4 or 6 respectively. The bit reads as 1 from the cycle after the strobe.
- R4: Status bit 5 sets in the cycle after ofq_head equals ofq_tail while ofq_full is 1. Equal pointers without the full flag, or the full flag without equal pointers, leave it unchanged.
- R5: Status bit 2 reads as the OR of db_fast_bits, and status bit 3 reads as db_norm_bit, both in the same cycle. Neither is stored here.
- R6: Writing 1 to status bit 0, 1, 4, 5 or 6 clears it from the next cycle. Writing 0 leaves it unchanged, and writes to bits 2 and 3 have no effect.
- R7: When a set event and a write-1 clear reach the same sticky bit in the same cycle, the bit ends up set.
- R8: irq_norm is the OR of status bits 3 and 5 and irq_fast is the OR of status bits 0, 1, 2, 4 and 6, in each case over unmasked bits only. Each output is registered and reflects the status of the previous cycle.
- R9: A mask bit of 1 keeps its status bit from driving an interrupt output. The status bit is still set and still reads as 1.
- R10: Each interrupt output goes low in the cycle after its last unmasked contributing status bit clears or becomes masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word index (0 status, 1 mask) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| msg0_wr_evt | input | 1 | Inbound message register 0 written |
| msg1_wr_evt | input | 1 | Inbound message register 1 written |
| post_q_wr_evt | input | 1 | Inbound post queue written |
| index_wr_evt | input | 1 | Index register written by a bus transaction |
| ofq_head | input | PTR_W | Outbound free-queue head pointer |
| ofq_tail | input | PTR_W | Outbound free-queue tail pointer |
| ofq_full | input | 1 | Outbound free-queue full flag |
| db_fast_bits | input | DB_W | Live fast-interrupt bits of the doorbell register |
| db_norm_bit | input | 1 | Live normal-interrupt bit of the doorbell register |
| irq_fast | output | 1 | Fast interrupt line to the processor |
| irq_norm | output | 1 | Normal interrupt line to the processor |

## Verification
The bench builds the block with 3-bit queue pointers and a 4-bit doorbell field. With pointers that narrow, random head and tail values match often, so the equality-and-full condition and its two near misses all occur many times. The short doorbell field lets fast-bit patterns range from all clear to several bits set, so the OR mirror is exercised on both its edges. Random word indices 2 and 3 cover the unmapped addresses, and 32-bit data covers the reserved-bit behaviour.

// File: rtl/inb_irq_pkg.sv
package inb_irq_pkg;

    localparam int NUM_SRC = 7;

    localparam int B_MSG0  = 0;
    localparam int B_MSG1  = 1;
    localparam int B_DBF   = 2;
    localparam int B_DBN   = 3;
    localparam int B_POST  = 4;
    localparam int B_QFULL = 5;
    localparam int B_INDEX = 6;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    // status bits that are held by flops here (the rest are live mirrors)
    localparam src_vec_t STICKY_SET = src_vec_t'(7'b111_0011);
    // routing of status bits to the two processor lines
    localparam src_vec_t NORM_ROUTE = src_vec_t'(7'b010_1000);
    localparam src_vec_t FAST_ROUTE = ~NORM_ROUTE;

    typedef enum logic [1:0] {
        SEL_STATUS,
        SEL_MASK,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic index_wr;
        logic qfull_hit;
        logic post_wr;
        logic msg1_wr;
        logic msg0_wr;
    } evt_t;

    function automatic src_vec_t evt_to_vec(evt_t e);
        src_vec_t v;
        v          = '0;
        v[B_MSG0]  = e.msg0_wr;
        v[B_MSG1]  = e.msg1_wr;
        v[B_POST]  = e.post_wr;
        v[B_QFULL] = e.qfull_hit;
        v[B_INDEX] = e.index_wr;
        return v;
    endfunction

    function automatic src_vec_t mirror_vec(logic fast_any, logic norm_lvl);
        src_vec_t v;
        v        = '0;
        v[B_DBF] = fast_any;
        v[B_DBN] = norm_lvl;
        return v;
    endfunction

endpackage

// File: rtl/inb_irq_sticky.sv
module inb_irq_sticky
    import inb_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t set_vec,
    input  src_vec_t clr_vec,
    output src_vec_t held_q
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        if (STICKY_SET[i]) begin : g_flop
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    bit_q <= 1'b0;
                end else if (set_vec[i]) begin
                    bit_q <= 1'b1;          // a set beats a same-cycle clear
                end else if (clr_vec[i]) begin
                    bit_q <= 1'b0;
                end
            end
            assign held_q[i] = bit_q;
        end else begin : g_none
            assign held_q[i] = 1'b0;
        end
    end

endmodule

// File: rtl/inb_irq_mask.sv
module inb_irq_mask
    import inb_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  src_vec_t wr_val,
    output src_vec_t mask_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wr_en) begin
            mask_q <= wr_val;
        end
    end

endmodule

// File: rtl/inb_irq_route.sv
module inb_irq_route
    import inb_irq_pkg::*;
#(
    parameter src_vec_t ROUTE = '0
) (
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t status,
    input  src_vec_t mask,
    output logic     irq_q
);

    logic pend;
    assign pend = |(status & ~mask & ROUTE);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= pend;
        end
    end

endmodule

// File: rtl/inb_irq_status.sv
module inb_irq_status
    import inb_irq_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 2,
    parameter int PTR_W      = 8,
    parameter int DB_W       = 4,
    parameter int STATUS_IDX = 0,
    parameter int MASK_IDX   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              msg0_wr_evt,
    input  logic              msg1_wr_evt,
    input  logic              post_q_wr_evt,
    input  logic              index_wr_evt,
    input  logic [PTR_W-1:0]  ofq_head,
    input  logic [PTR_W-1:0]  ofq_tail,
    input  logic              ofq_full,
    input  logic [DB_W-1:0]   db_fast_bits,
    input  logic              db_norm_bit,
    output logic              irq_fast,
    output logic              irq_norm
);

    localparam int PAD_W = DATA_W - NUM_SRC;

    reg_sel_e sel;
    evt_t     evt;
    src_vec_t wr_low;
    src_vec_t set_vec;
    src_vec_t clr_vec;
    src_vec_t held_q;
    src_vec_t status_vec;
    src_vec_t mask_vec;
    logic     unused_wdata_hi;

    always_comb begin
        if (reg_addr == ADDR_W'(STATUS_IDX)) begin
            sel = SEL_STATUS;
        end else if (reg_addr == ADDR_W'(MASK_IDX)) begin
            sel = SEL_MASK;
        end else begin
            sel = SEL_NONE;
        end
    end

    assign wr_low          = reg_wdata[NUM_SRC-1:0];
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_SRC];

    always_comb begin
        evt.msg0_wr   = msg0_wr_evt;
        evt.msg1_wr   = msg1_wr_evt;
        evt.post_wr   = post_q_wr_evt;
        evt.index_wr  = index_wr_evt;
        evt.qfull_hit = ofq_full && (ofq_head == ofq_tail);
    end

    assign set_vec = evt_to_vec(evt);
    assign clr_vec = (reg_wr && sel == SEL_STATUS) ? (wr_low & STICKY_SET) : '0;

    inb_irq_sticky u_sticky (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .held_q  (held_q)
    );

    inb_irq_mask u_mask (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (reg_wr && sel == SEL_MASK),
        .wr_val (wr_low),
        .mask_q (mask_vec)
    );

    assign status_vec = held_q | mirror_vec(|db_fast_bits, db_norm_bit);

    inb_irq_route #(.ROUTE(FAST_ROUTE)) u_route_fast (
        .clk    (clk),
        .rst    (rst),
        .status (status_vec),
        .mask   (mask_vec),
        .irq_q  (irq_fast)
    );

    inb_irq_route #(.ROUTE(NORM_ROUTE)) u_route_norm (
        .clk    (clk),
        .rst    (rst),
        .status (status_vec),
        .mask   (mask_vec),
        .irq_q  (irq_norm)
    );

    always_comb begin
        unique case (sel)
            SEL_STATUS: reg_rdata = {{PAD_W{1'b0}}, status_vec};
            SEL_MASK:   reg_rdata = {{PAD_W{1'b0}}, mask_vec};
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/inb_irq_status_chk.sv
module inb_irq_status_chk
    import inb_irq_pkg::*;
#(
    parameter int ADDR_W     = 2,
    parameter int PTR_W      = 8,
    parameter int STATUS_IDX = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [1:0]        wd_lo,
    input logic              msg0_wr_evt,
    input logic [PTR_W-1:0]  ofq_head,
    input logic [PTR_W-1:0]  ofq_tail,
    input logic              ofq_full,
    input src_vec_t          status_q,
    input src_vec_t          mask_q,
    input logic              irq_fast,
    input logic              irq_norm
);

    logic st_wr;
    assign st_wr = reg_wr && (reg_addr == ADDR_W'(STATUS_IDX));

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!irq_fast && !irq_norm && mask_q == '0));

    // R3
    msg0_set_chk: assert property (@(posedge clk) disable iff (rst)
        msg0_wr_evt |=> status_q[B_MSG0]);

    // R4
    qfull_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ofq_full && ofq_head == ofq_tail) |=> status_q[B_QFULL]);

    // R6
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (st_wr && wd_lo[0] && !msg0_wr_evt) |=> !status_q[B_MSG0]);

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (status_q[B_MSG1] && !(st_wr && wd_lo[1])) |=> status_q[B_MSG1]);

    // R10
    fast_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((status_q & ~mask_q & FAST_ROUTE) == '0) |=> !irq_fast);

    // R8
    norm_raise_chk: assert property (@(posedge clk) disable iff (rst)
        ((status_q & ~mask_q & NORM_ROUTE) != '0) |=> irq_norm);

endmodule

bind inb_irq_status inb_irq_status_chk #(
    .ADDR_W     (ADDR_W),
    .PTR_W      (PTR_W),
    .STATUS_IDX (STATUS_IDX)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .wd_lo       (reg_wdata[1:0]),
    .msg0_wr_evt (msg0_wr_evt),
    .ofq_head    (ofq_head),
    .ofq_tail    (ofq_tail),
    .ofq_full    (ofq_full),
    .status_q    (status_vec),
    .mask_q      (mask_vec),
    .irq_fast    (irq_fast),
    .irq_norm    (irq_norm)
);

// File: tb/inb_irq_status_tb.sv
module inb_irq_status_tb;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;
    localparam int PTR_W  = 3;
    localparam int DB_W   = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              msg0_wr_evt = 1'b0;
    logic              msg1_wr_evt = 1'b0;
    logic              post_q_wr_evt = 1'b0;
    logic              index_wr_evt = 1'b0;
    logic [PTR_W-1:0]  ofq_head = '0;
    logic [PTR_W-1:0]  ofq_tail = '0;
    logic              ofq_full = 1'b0;
    logic [DB_W-1:0]   db_fast_bits = '0;
    logic              db_norm_bit = 1'b0;
    logic              irq_fast;
    logic              irq_norm;

    int  vectors = 0;
    int  fails = 0;
    bit  done = 1'b0;

    logic [6:0] m_sticky = '0;
    logic [6:0] m_mask = '0;
    logic       m_fast = 1'b0;
    logic       m_norm = 1'b0;

    localparam logic [6:0] T_NORM   = 7'b010_1000;
    localparam logic [6:0] T_FAST   = 7'b101_0111;
    localparam logic [6:0] T_STICKY = 7'b111_0011;

    always #10 clk = ~clk;

    inb_irq_status #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .PTR_W  (PTR_W),
        .DB_W   (DB_W)
    ) u_dut (
        .clk           (clk),
        .rst           (rst),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .msg0_wr_evt   (msg0_wr_evt),
        .msg1_wr_evt   (msg1_wr_evt),
        .post_q_wr_evt (post_q_wr_evt),
        .index_wr_evt  (index_wr_evt),
        .ofq_head      (ofq_head),
        .ofq_tail      (ofq_tail),
        .ofq_full      (ofq_full),
        .db_fast_bits  (db_fast_bits),
        .db_norm_bit   (db_norm_bit),
        .irq_fast      (irq_fast),
        .irq_norm      (irq_norm)
    );

    function automatic logic [6:0] exp_status();
        logic [6:0] v;
        v    = m_sticky;
        v[2] = |db_fast_bits;
        v[3] = db_norm_bit;
        return v;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        reg_wr   = 1'b0;
        reg_addr = 2'd0;
        #1 chk(tag, "status", reg_rdata, {25'b0, exp_status()});
        reg_addr = 2'd1;
        #1 chk(tag, "mask", reg_rdata, {25'b0, m_mask});
        reg_addr = 2'd2;
        #1 chk(tag, "unmapped", reg_rdata, 32'h0);
        chk(tag, "irq_fast", {31'b0, irq_fast}, {31'b0, m_fast});
        chk(tag, "irq_norm", {31'b0, irq_norm}, {31'b0, m_norm});
    endtask

    // drive one cycle just after a falling edge, advance the model, return at the next falling edge
    task automatic step(input logic wr, input logic [1:0] addr, input logic [31:0] wd,
                        input logic [3:0] ev, input logic [2:0] hd, input logic [2:0] tl,
                        input logic full, input logic [3:0] dbf, input logic dbn);
        logic [6:0] cur, setv, clrv;
        reg_wr        = wr;
        reg_addr      = addr;
        reg_wdata     = wd;
        msg0_wr_evt   = ev[0];
        msg1_wr_evt   = ev[1];
        post_q_wr_evt = ev[2];
        index_wr_evt  = ev[3];
        ofq_head      = hd;
        ofq_tail      = tl;
        ofq_full      = full;
        db_fast_bits  = dbf;
        db_norm_bit   = dbn;
        cur    = exp_status();
        m_fast = |(cur & ~m_mask & T_FAST);
        m_norm = |(cur & ~m_mask & T_NORM);
        setv   = {ev[3], (full && hd == tl), ev[2], 2'b00, ev[1], ev[0]};
        clrv   = (wr && addr == 2'd0) ? (wd[6:0] & T_STICKY) : 7'h0;
        m_sticky = (m_sticky & ~clrv) | setv;
        if (wr && addr == 2'd1) m_mask = wd[6:0];
        @(posedge clk);
        @(negedge clk);
        msg0_wr_evt   = 1'b0;
        msg1_wr_evt   = 1'b0;
        post_q_wr_evt = 1'b0;
        index_wr_evt  = 1'b0;
        reg_wr        = 1'b0;
    endtask

    task automatic idle();
        step(1'b0, 2'd0, 32'h0, 4'h0, 3'd1, 3'd2, 1'b0, db_fast_bits, db_norm_bit);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all("R1 reset");

        // R3 message 0 strobe, then R8 fast line one cycle later
        step(1'b0, 2'd0, 32'h0, 4'b0001, 3'd1, 3'd2, 1'b0, 4'h0, 1'b0);
        check_all("R3 msg0 set");
        idle();
        check_all("R8 fast raise");

        // R6 writing zero keeps, writing one clears; R10 drop
        step(1'b1, 2'd0, 32'hFFFF_FF80, 4'h0, 3'd1, 3'd2, 1'b0, 4'h0, 1'b0);
        check_all("R6 write zero");
        step(1'b1, 2'd0, 32'h0000_0001, 4'h0, 3'd1, 3'd2, 1'b0, 4'h0, 1'b0);
        check_all("R6 w1c");
        idle();
        check_all("R10 fast drop");

        // R7 set beats clear on the same bit
        step(1'b1, 2'd0, 32'h0000_0002, 4'b0010, 3'd1, 3'd2, 1'b0, 4'h0, 1'b0);
        check_all("R7 set wins");

        // R4 free-queue full qualification
        step(1'b0, 2'd0, 32'h0, 4'h0, 3'd5, 3'd5, 1'b0, 4'h0, 1'b0);
        check_all("R4 equal no full");
        step(1'b0, 2'd0, 32'h0, 4'h0, 3'd5, 3'd6, 1'b1, 4'h0, 1'b0);
        check_all("R4 full no equal");
        step(1'b0, 2'd0, 32'h0, 4'h0, 3'd3, 3'd3, 1'b1, 4'h0, 1'b0);
        check_all("R4 full hit");
        idle();
        check_all("R8 norm raise");

        // R5 doorbell mirrors and R6 ignored writes to them
        step(1'b0, 2'd0, 32'h0, 4'h0, 3'd1, 3'd2, 1'b0, 4'b0100, 1'b1);
        check_all("R5 mirror on");
        step(1'b1, 2'd0, 32'h0000_000C, 4'h0, 3'd1, 3'd2, 1'b0, 4'b0100, 1'b1);
        check_all("R6 mirror write ignored");
        step(1'b0, 2'd0, 32'h0, 4'h0, 3'd1, 3'd2, 1'b0, 4'b0000, 1'b0);
        check_all("R5 mirror off");

        // R2 reserved mask bits and unmapped index; R9 masking
        step(1'b1, 2'd1, 32'hFFFF_FFFF, 4'h0, 3'd1, 3'd2, 1'b0, 4'h0, 1'b0);
        check_all("R2 mask reserved");
        step(1'b1, 2'd3, 32'h0000_0000, 4'b1111, 3'd1, 3'd2, 1'b0, 4'hF, 1'b1);
        check_all("R2 unmapped write");
        idle();
        check_all("R9 masked recorded");
        step(1'b1, 2'd0, 32'h0000_007F, 4'h0, 3'd1, 3'd2, 1'b0, 4'h0, 1'b0);
        step(1'b1, 2'd1, 32'h0000_0000, 4'h0, 3'd1, 3'd2, 1'b0, 4'h0, 1'b0);
        idle();
        check_all("R10 clean");

        // random mix covering R2..R10
        for (int i = 0; i < 4000; i++) begin
            logic        w;
            logic [1:0]  a;
            logic [31:0] d;
            logic [3:0]  e;
            w = ($urandom % 4) == 0;
            a = 2'($urandom % 4);
            d = $urandom;
            e = 4'($urandom) & 4'($urandom);
            step(w, a, d, e, 3'($urandom), 3'($urandom), ($urandom % 3) == 0,
                 4'($urandom) & 4'($urandom) & 4'($urandom), ($urandom % 5) == 0);
            check_all("R2-mix R6 R8 R9 R10 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule